// File: doc/BRIEF.md
# Event Status and Interrupt Vector Controller

This block collects event flags for a bus transfer controller and turns them into one level interrupt and two DMA request lines. The transfer engine raises any of sixteen status bits with single-cycle set pulses. Software reads and writes four registers through a simple register port. These registers are an enable mask over the six lowest event bits, the status word, a vector register, and a DMA enable register with one bit for each transfer direction.

Two register models are available, and the `NEW_REV` parameter chooses between them. With the older model (`NEW_REV = 0`) the status word is read-only. Software acknowledges an event by reading the vector register, which returns the number of the lowest pending enabled event and clears that event in the same access. With the newer model (`NEW_REV = 1`) the vector register returns zero, and software clears events by writing ones to the status word. Read data is registered and appears one cycle after the read request.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the mask, status and DMA enables are zero, `irq`, `dma_rx_req` and `dma_tx_req` are low, and reads of every register return 0.
- R2: `irq` is high exactly when at least one of status bits 5..0 is set together with the matching mask bit.
- R3: A write to the mask address (0) keeps data bits 5..0 when NEW_REV=1 and only bits 4..0 when NEW_REV=0. A read of address 0 returns the mask zero-extended.
- R4: When NEW_REV=0, a read of the vector address (2) returns i+1, where i is the lowest bit set in (status[5:0] AND mask), and clears status bit i. It returns 0 and changes nothing when no such bit is set.
- R5: When NEW_REV=1, a read of address 2 returns 0 and leaves the status unchanged.
- R6: When NEW_REV=1, a write to the status address (1) clears each of status bits 0, 1, 2 and 5 that is written as 1, and leaves every other bit unchanged. When NEW_REV=0, that write has no effect.
- R7: A read of address 1 returns the stored status with bit 12 ORed with the `bus_busy` input sampled in the read cycle.
- R8: A write to the DMA address (3) keeps only data bit 15 (receive enable) and bit 7 (transmit enable), and reads back in those positions. Writing bit 15 as 1 clears mask bit 3, and writing bit 7 as 1 clears mask bit 4.
- R9: `dma_rx_req` equals the receive enable AND status bit 3. `dma_tx_req` equals the transmit enable AND status bit 4.
- R10: A set pulse on `evt_set` bit k leaves status bit k set after that edge, even when a status write or a vector read clears bit k in the same cycle.
- R11: `rd_data` is updated on the clock edge that samples `rd_en`. Addresses 4..7 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Registered read data |
| evt_set | input | 16 | Single-cycle event set pulses from the transfer engine |
| bus_busy | input | 1 | Live bus-busy indication shown in status bit 12 |
| irq | output | 1 | Level interrupt |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
The hardest case to reach is a clear and a set that target the same status bit on the same clock edge. On the older model the clear comes from a vector read of the lowest pending bit. On the newer model it comes from a write-one-to-clear. The stimulus first makes bit 0 the lowest pending enabled event. In a single cycle it then issues a status write of bit 0, a vector read and a set pulse on bit 0. A status read afterwards shows the bit still set on both models, and on the older model the vector read returns 1. Both models are instantiated side by side on the same inputs, so every access also shows how their responses differ.

// File: rtl/evt_irq_pkg.sv
// Shared constants for the event status and interrupt vector controller.
// Assumes a 16-bit register data path and a 3-bit register address.
package evt_irq_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 16;
    localparam int EVT_W  = 6;

    localparam logic [ADDR_W-1:0] RA_MASK = 3'd0;
    localparam logic [ADDR_W-1:0] RA_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] RA_VEC  = 3'd2;
    localparam logic [ADDR_W-1:0] RA_DMA  = 3'd3;

    localparam int RX_RDY_BIT = 3;
    localparam int TX_RDY_BIT = 4;
    localparam int BUSY_BIT   = 12;
    localparam int RX_EN_BIT  = 15;
    localparam int TX_EN_BIT  = 7;

    localparam logic [DATA_W-1:0] W1C_BITS = 16'h0027;
endpackage

// File: rtl/evt_prio_enc.sv
// Lowest-index-first priority encoder.
// Assumes W >= 2. Reports whether any request is set, the index of the lowest
// set request, and that request as a one-hot vector.
module evt_prio_enc #(
    parameter int W = 6,
    localparam int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx,
    output logic [W-1:0]     onehot
);
    // Scan from the top down so that the lowest set index is written last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

    // Isolate the lowest set bit.
    assign onehot = req & (~req + W'(1));
endmodule

// File: rtl/evt_stat_reg.sv
// Status flag register: bits are cleared by clr_i and set by set_i.
// Assumes set and clear may coincide; the set always wins.
module evt_stat_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);
    // Apply the clears first, then OR in the sets.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_o <= '0;
        else        stat_o <= (stat_o & ~clr_i) | set_i;
    end
endmodule

// File: rtl/evt_cfg_reg.sv
// Holds the interrupt enable mask and the two DMA direction enables.
// Assumes mask_we and dma_we are never high together (they decode one address).
// Turning a DMA direction on drops the ready-interrupt enable for that direction.
module evt_cfg_reg #(
    parameter int EVT_W   = 6,
    parameter bit NEW_REV = 1'b1,
    parameter int RX_MBIT = 3,
    parameter int TX_MBIT = 4,
    localparam int KEEP_W = NEW_REV ? EVT_W : EVT_W - 1,
    localparam logic [EVT_W-1:0] KEEP_MASK = {EVT_W{1'b1}} >> (EVT_W - KEEP_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_we,
    input  logic [EVT_W-1:0] mask_wdata,
    input  logic             dma_we,
    input  logic             rx_en_wdata,
    input  logic             tx_en_wdata,
    output logic [EVT_W-1:0] mask_o,
    output logic             rx_en_o,
    output logic             tx_en_o
);
    // Mask register: plain writes, trimmed to the revision width; DMA enables knock out ready bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o <= '0;
        end else if (mask_we) begin
            mask_o <= mask_wdata & KEEP_MASK;
        end else if (dma_we) begin
            if (rx_en_wdata) mask_o[RX_MBIT] <= 1'b0;
            if (tx_en_wdata) mask_o[TX_MBIT] <= 1'b0;
        end
    end

    // DMA direction enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en_o <= 1'b0;
            tx_en_o <= 1'b0;
        end else if (dma_we) begin
            rx_en_o <= rx_en_wdata;
            tx_en_o <= tx_en_wdata;
        end
    end
endmodule

// File: rtl/evt_irq_ctrl.sv
// Event status and interrupt vector controller (top).
// Assumes event set pulses last one cycle and that register reads and writes
// may occur in the same cycle. NEW_REV picks write-one-to-clear (1) or
// vector-read acknowledge (0).
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter bit NEW_REV = 1'b1,
    localparam int IDX_W = $clog2(EVT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] evt_set,
    input  logic              bus_busy,
    output logic              irq,
    output logic              dma_rx_req,
    output logic              dma_tx_req
);
    logic [DATA_W-1:0] stat_q;
    logic [EVT_W-1:0]  mask_q;
    logic              rx_en_q, tx_en_q;
    logic [EVT_W-1:0]  pending;
    logic              pend_found;
    logic [IDX_W-1:0]  pend_idx;
    logic [EVT_W-1:0]  pend_onehot;
    logic              mask_we, dma_we, stat_we, vec_rd;
    logic [DATA_W-1:0] clr_vec, vec_val, rd_next;

    // Write decode for each register.
    assign mask_we = wr_en && (wr_addr == RA_MASK);
    assign dma_we  = wr_en && (wr_addr == RA_DMA);

    // Revision-dependent acknowledge paths.
    generate
        if (NEW_REV) begin : g_w1c
            assign stat_we = wr_en && (wr_addr == RA_STAT);
            assign vec_rd  = 1'b0;
        end else begin : g_vec
            assign stat_we = 1'b0;
            assign vec_rd  = rd_en && (rd_addr == RA_VEC);
        end
    endgenerate

    evt_cfg_reg #(
        .EVT_W  (EVT_W),
        .NEW_REV(NEW_REV),
        .RX_MBIT(RX_RDY_BIT),
        .TX_MBIT(TX_RDY_BIT)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_we    (mask_we),
        .mask_wdata (wr_data[EVT_W-1:0]),
        .dma_we     (dma_we),
        .rx_en_wdata(wr_data[RX_EN_BIT]),
        .tx_en_wdata(wr_data[TX_EN_BIT]),
        .mask_o     (mask_q),
        .rx_en_o    (rx_en_q),
        .tx_en_o    (tx_en_q)
    );

    assign pending = stat_q[EVT_W-1:0] & mask_q;

    evt_prio_enc #(.W(EVT_W)) u_prio (
        .req   (pending),
        .found (pend_found),
        .idx   (pend_idx),
        .onehot(pend_onehot)
    );

    // Gather the clears from the status write and the vector acknowledge.
    always_comb begin
        clr_vec = '0;
        if (stat_we) clr_vec = clr_vec | (wr_data & W1C_BITS);
        if (vec_rd)  clr_vec = clr_vec | {{(DATA_W-EVT_W){1'b0}}, pend_onehot};
    end

    evt_stat_reg #(.W(DATA_W)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_set),
        .clr_i (clr_vec),
        .stat_o(stat_q)
    );

    // Output lines derived from the current register state.
    assign irq        = |pending;
    assign dma_rx_req = rx_en_q && stat_q[RX_RDY_BIT];
    assign dma_tx_req = tx_en_q && stat_q[TX_RDY_BIT];

    // Vector value: lowest pending index plus one, zero if none.
    assign vec_val = pend_found ? (DATA_W'(pend_idx) + DATA_W'(1)) : '0;

    // Read multiplexer.
    always_comb begin
        rd_next = '0;
        case (rd_addr)
            RA_MASK: rd_next = DATA_W'(mask_q);
            RA_STAT: rd_next = stat_q | (DATA_W'(bus_busy) << BUSY_BIT);
            RA_VEC:  rd_next = NEW_REV ? '0 : vec_val;
            RA_DMA:  rd_next = (DATA_W'(rx_en_q) << RX_EN_BIT) | (DATA_W'(tx_en_q) << TX_EN_BIT);
            default: rd_next = '0;
        endcase
    end

    // Register the read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
// Assertion checker for evt_irq_ctrl, attached by bind.
// Assumes the register address constants from evt_irq_pkg.
module evt_irq_ctrl_chk
    import evt_irq_pkg::*;
#(
    parameter bit NEW_REV = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] evt_set,
    input logic [DATA_W-1:0] stat_q,
    input logic [EVT_W-1:0]  mask_q
);
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != '0) |=> ((stat_q & $past(evt_set)) == $past(evt_set))); // R10

    AST_DMA_RX_DROPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_DMA && wr_data[RX_EN_BIT]) |=> !mask_q[RX_RDY_BIT]); // R8

    AST_DMA_TX_DROPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_DMA && wr_data[TX_EN_BIT]) |=> !mask_q[TX_RDY_BIT]); // R8

    generate
        if (NEW_REV) begin : g_new
            AST_VEC_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_en && rd_addr == RA_VEC && evt_set == '0 && !wr_en) |=> $stable(stat_q)); // R5
        end else begin : g_old
            AST_STAT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_addr == RA_STAT && evt_set == '0 && !rd_en) |=> $stable(stat_q)); // R6
            AST_VEC_CLEARS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_en && rd_addr == RA_VEC && ((stat_q[EVT_W-1:0] & mask_q) != '0)
                 && evt_set == '0 && !wr_en)
                |=> ($countones(stat_q) + 1 == $countones($past(stat_q)))); // R4
        end
    endgenerate
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(.NEW_REV(NEW_REV)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .evt_set(evt_set),
    .stat_q (stat_q),
    .mask_q (mask_q)
);

// File: tb/evt_irq_ctrl_test.sv
// Scoreboard bench: both revisions share one stimulus stream. The driver task
// updates a behavioural model and queues the expected read data. The monitor
// pops the queue when the read result appears.
module evt_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, bus_busy = 1'b0;
    logic [2:0]  wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0, evt_set = '0;
    logic [15:0] rd_data_o, rd_data_n;
    logic        irq_o, irq_n, rxq_o, rxq_n, txq_o, txq_n;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [15:0] exp_o;
        logic [15:0] exp_n;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    // Model state: index 0 = older revision, 1 = newer revision.
    logic [15:0] m_stat [2];
    logic [5:0]  m_mask [2];
    logic        m_rx   [2];
    logic        m_tx   [2];

    always #5 clk = ~clk;

    evt_irq_ctrl #(.NEW_REV(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data_n), .evt_set(evt_set),
        .bus_busy(bus_busy), .irq(irq_n), .dma_rx_req(rxq_n), .dma_tx_req(txq_n)
    );

    evt_irq_ctrl #(.NEW_REV(1'b0)) uut_old (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data_o), .evt_set(evt_set),
        .bus_busy(bus_busy), .irq(irq_o), .dma_rx_req(rxq_o), .dma_tx_req(txq_o)
    );

    task automatic compare(input logic [15:0] act, input logic [15:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // One register cycle: drive at a falling edge, update the model, return at the next falling edge.
    task automatic step(input logic w, input logic [2:0] wa, input logic [15:0] wd,
                        input logic r, input logic [2:0] ra, input logic [15:0] s, input string tag);
        exp_t e;
        logic [15:0] rdv [2];
        wr_en = w; wr_addr = wa; wr_data = wd;
        rd_en = r; rd_addr = ra; evt_set = s;
        for (int k = 0; k < 2; k++) begin
            logic [5:0]  pend;
            logic [15:0] clr;
            logic [15:0] vec;
            int          low;
            pend = m_stat[k][5:0] & m_mask[k];
            low  = -1;
            for (int i = 5; i >= 0; i--) if (pend[i]) low = i;
            vec = (low >= 0) ? 16'(low + 1) : 16'h0;
            case (ra)
                3'd0:    rdv[k] = {10'h0, m_mask[k]};
                3'd1:    rdv[k] = m_stat[k] | (16'(bus_busy) << 12);
                3'd2:    rdv[k] = (k == 0) ? vec : 16'h0;
                3'd3:    rdv[k] = {m_rx[k], 7'h0, m_tx[k], 7'h0};
                default: rdv[k] = 16'h0;
            endcase
            clr = '0;
            if (w && wa == 3'd1 && k == 1) clr = wd & 16'h0027;
            if (r && ra == 3'd2 && k == 0 && low >= 0) clr[low] = 1'b1;
            if (w && wa == 3'd0) m_mask[k] = wd[5:0] & ((k == 1) ? 6'h3F : 6'h1F);
            if (w && wa == 3'd3) begin
                m_rx[k] = wd[15];
                m_tx[k] = wd[7];
                if (wd[15]) m_mask[k][3] = 1'b0;
                if (wd[7])  m_mask[k][4] = 1'b0;
            end
            m_stat[k] = (m_stat[k] & ~clr) | s;
        end
        if (r) begin
            e.exp_o = rdv[0];
            e.exp_n = rdv[1];
            e.tag   = tag;
            sb_q.push_back(e);
        end
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; evt_set = '0;
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        step(1'b0, 3'd0, 16'h0, 1'b1, a, 16'h0, tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d, input string tag);
        step(1'b1, a, d, 1'b0, 3'd0, 16'h0, tag);
    endtask

    // Compare the interrupt and DMA lines of both instances against the model.
    task automatic check_lines(input string tag);
        compare(16'(irq_o), 16'(|(m_stat[0][5:0] & m_mask[0])), {tag, " irq old"});
        compare(16'(irq_n), 16'(|(m_stat[1][5:0] & m_mask[1])), {tag, " irq new"});
        compare(16'(rxq_o), 16'(m_rx[0] & m_stat[0][3]), {tag, " rx dma old"});
        compare(16'(rxq_n), 16'(m_rx[1] & m_stat[1][3]), {tag, " rx dma new"});
        compare(16'(txq_o), 16'(m_tx[0] & m_stat[0][4]), {tag, " tx dma old"});
        compare(16'(txq_n), 16'(m_tx[1] & m_stat[1][4]), {tag, " tx dma new"});
    endtask

    // Monitor: after each edge that samples a read, compare at the next falling edge.
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                @(negedge clk);
                if (sb_q.size() == 0) begin
                    compare(16'h1, 16'h0, "R11 unexpected read result");
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    compare(rd_data_o, e.exp_o, {e.tag, " old"});
                    compare(rd_data_n, e.exp_n, {e.tag, " new"});
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #2000000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < 2; k++) begin
            m_stat[k] = '0; m_mask[k] = '0; m_rx[k] = 1'b0; m_tx[k] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        check_lines("R1");
        rd(3'd0, "R1 mask");
        rd(3'd1, "R1 status");
        rd(3'd3, "R1 dma");

        // R3: mask width per revision.
        wr(3'd0, 16'h00FF, "R3");
        rd(3'd0, "R3 mask");

        // R2: pending events raise the interrupt.
        step(1'b0, 3'd0, 16'h0, 1'b0, 3'd0, 16'h0025, "R2 set");
        check_lines("R2");

        // R4 / R5: vector reads (old: 1, 3, then 0 as bit 5 is not enabled).
        rd(3'd2, "R4 R5 vector first");
        rd(3'd2, "R4 R5 vector second");
        rd(3'd2, "R4 R5 vector none");
        rd(3'd1, "R4 status after acks");
        check_lines("R2 after acks");

        // R7: live busy bit.
        bus_busy = 1'b1;
        rd(3'd1, "R7 busy");
        bus_busy = 1'b0;

        // R6: write-one-to-clear only on bits 0,1,2,5; ignored on old model.
        step(1'b0, 3'd0, 16'h0, 1'b0, 3'd0, 16'h013F, "R6 set");
        wr(3'd1, 16'hFFFF, "R6");
        rd(3'd1, "R6 status");

        // R11: unmapped addresses.
        rd(3'd5, "R11 unmapped");
        rd(3'd7, "R11 unmapped top");

        // R8 / R9: DMA enables.
        wr(3'd0, 16'h003F, "R8 mask");
        wr(3'd3, 16'hFFFF, "R8");
        rd(3'd3, "R8 dma");
        rd(3'd0, "R8 mask after dma");
        check_lines("R9 both on");
        wr(3'd3, 16'h0080, "R9");
        check_lines("R9 rx off");

        // R10: set and clear of the same bit in one cycle.
        wr(3'd0, 16'h0007, "R10 mask");
        step(1'b0, 3'd0, 16'h0, 1'b0, 3'd0, 16'h0001, "R10 pre");
        step(1'b1, 3'd1, 16'h0001, 1'b1, 3'd2, 16'h0001, "R10 vector");
        rd(3'd1, "R10 status");

        // R2: clearing the mask drops the interrupt.
        wr(3'd0, 16'h0000, "R2 mask off");
        check_lines("R2 mask off");

        @(negedge clk);
        compare(16'(sb_q.size()), 16'h0, "R11 outstanding reads");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule